// File: doc/BRIEF.md
# Two-Buffer Chaining DMA Channel

This block is one DMA channel that moves 32-bit words between a streaming peripheral port and a memory bus master port. Software programs a current pointer pair (next, limit) and an optional follow-on pair (start, stop) through a small register window, then starts the channel with command bits written to a control/status word. The channel performs one memory access per word and advances the next pointer by one word each time. A buffer is finished when the next pointer reaches the limit pointer.

If the one-shot chain bit is armed when the first buffer finishes, the channel reports completion, reloads next and limit from start and stop, disarms the chain bit and keeps running into the second buffer. Otherwise it reports completion and stops. A memory bus error freezes the channel, raises a bus-fault flag and copies the four live pointers into a saved set so software can resume the transfer later. An interrupt line is raised while either completion or bus fault is pending.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset all status flags, the direction bit and every pointer read as zero, no memory request is issued and irq is low.
- R2: Writes to the next, limit, start, stop and init-next registers store the value with its low 4 address bits cleared (16-byte alignment); reading back 0x1004 written to next gives 0x1000.
- R3: The CSR (index 0) reads enable at bit 24, chain-armed at bit 25, complete at bit 27, bus fault at bit 28 and direction at bit 18; a CSR write takes bit 16 = set enable, 17 = arm chain, 18 = direction (1 = device to memory), 19 = conditional clear-complete, 20 = reset flags, 21 = flush holding register. Register indices: 1..4 saved next/limit/start/stop, 5..8 next/limit/start/stop, 9 init-next.
- R4: In device-to-memory mode each accepted device word is written to memory at the next pointer, next advances by 4 per acknowledged write, and when next reaches limit without the chain armed the channel sets complete and clears enable.
- R5: In memory-to-device mode words read from memory at ascending addresses are presented on the device output in order.
- R6: When a buffer completes with the chain armed, complete is set, next and limit are loaded from start and stop, the chain bit clears and enable stays set, so the second buffer is transferred.
- R7: Clear-complete clears the complete flag only while enable is set; with enable clear it has no effect.
- R8: The reset command clears enable, chain-armed, complete and bus fault in one write.
- R9: A bus error on a memory access sets bus fault, clears enable, leaves next unadvanced, copies next, limit, start and stop into the saved registers and stops all further requests; an error wins over an acknowledge in the same cycle, so no completion or chain happens for that word.
- R10: irq is high exactly while complete or bus fault is set.
- R11: Writing init-next loads the next pointer and empties the holding register; the CSR flush bit also empties it.
- R12: A pending memory request keeps its request, address, direction and write data stable until acknowledged or errored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register index for reads and writes |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| dev_in_valid | input | 1 | Peripheral offers a word (device to memory) |
| dev_in_data | input | DATA_W | Peripheral word in |
| dev_in_ready | output | 1 | Channel accepts the offered word |
| dev_out_valid | output | 1 | Channel presents a word (memory to device) |
| dev_out_data | output | DATA_W | Word to peripheral |
| dev_out_ready | input | 1 | Peripheral takes the presented word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed with a bus error |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can coincide are the bus-error response and buffer completion with chaining: the last word of a buffer can receive an acknowledge and an error in the same cycle. The bench provokes this by programming a chained transfer whose final first-buffer address is the faulting address, with the memory model raising both acknowledge and error there. It judges that bus fault wins: complete stays clear, the chain bit stays armed, next stays on the faulting word, the saved registers hold the pre-fault pointers and no write at that address reaches the scoreboard.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int REG_W = 32;

    // CSR read positions
    localparam int CSR_EN_RD  = 24;
    localparam int CSR_SUP_RD = 25;
    localparam int CSR_CMP_RD = 27;
    localparam int CSR_BEX_RD = 28;

    // CSR command positions
    localparam int CMD_SET_EN  = 16;
    localparam int CMD_SET_SUP = 17;
    localparam int CMD_DIR     = 18;
    localparam int CMD_CLR_CMP = 19;
    localparam int CMD_RESET   = 20;
    localparam int CMD_FLUSH   = 21;
    localparam int CMD_W       = CMD_RESET - CMD_SET_EN + 1;

    typedef enum logic [3:0] {
        RI_CSR       = 4'd0,
        RI_SV_NEXT   = 4'd1,
        RI_SV_LIMIT  = 4'd2,
        RI_SV_START  = 4'd3,
        RI_SV_STOP   = 4'd4,
        RI_NEXT      = 4'd5,
        RI_LIMIT     = 4'd6,
        RI_START     = 4'd7,
        RI_STOP      = 4'd8,
        RI_INIT_NEXT = 4'd9
    } reg_idx_e;

    typedef struct packed {
        logic en;
        logic sup;
        logic cmp;
        logic bex;
        logic d2m;
    } chan_flags_t;

    function automatic logic [REG_W-1:0] csr_view(chan_flags_t f);
        logic [REG_W-1:0] v;
        v             = '0;
        v[CSR_EN_RD]  = f.en;
        v[CSR_SUP_RD] = f.sup;
        v[CSR_CMP_RD] = f.cmp;
        v[CSR_BEX_RD] = f.bex;
        v[CMD_DIR]    = f.d2m;
        return v;
    endfunction

endpackage

// File: rtl/dmac_ptrs.sv
module dmac_ptrs
    import dmac_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ALIGN_LSB = 4,
    parameter int STEP_B    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  reg_idx_e          sw_idx,
    input  logic [ADDR_W-1:0] sw_data,
    input  logic              beat_done,
    input  logic              chain,
    input  logic              fault,
    output logic [ADDR_W-1:0] next_q,
    output logic [ADDR_W-1:0] limit_q,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] stop_q,
    output logic [ADDR_W-1:0] sv_next_q,
    output logic [ADDR_W-1:0] sv_limit_q,
    output logic [ADDR_W-1:0] sv_start_q,
    output logic [ADDR_W-1:0] sv_stop_q,
    output logic              last_beat
);
    localparam logic [ADDR_W-1:0] LOW_BITS = ADDR_W'((64'd1 << ALIGN_LSB) - 64'd1);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~LOW_BITS;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_B);

    logic [ADDR_W-1:0] next_inc;
    logic [ADDR_W-1:0] sw_aligned;

    assign next_inc   = next_q + STEP;
    assign last_beat  = (next_inc == limit_q);
    assign sw_aligned = sw_data & ALIGN_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_q     <= '0;
            limit_q    <= '0;
            start_q    <= '0;
            stop_q     <= '0;
            sv_next_q  <= '0;
            sv_limit_q <= '0;
            sv_start_q <= '0;
            sv_stop_q  <= '0;
        end else begin
            if (fault) begin
                sv_next_q  <= next_q;
                sv_limit_q <= limit_q;
                sv_start_q <= start_q;
                sv_stop_q  <= stop_q;
            end else if (beat_done) begin
                next_q <= chain ? start_q : next_inc;
                if (chain) begin
                    limit_q <= stop_q;
                end
            end
            if (sw_we) begin
                case (sw_idx)
                    RI_NEXT, RI_INIT_NEXT: next_q  <= sw_aligned;
                    RI_LIMIT:              limit_q <= sw_aligned;
                    RI_START:              start_q <= sw_aligned;
                    RI_STOP:               stop_q  <= sw_aligned;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dmac_flags.sv
module dmac_flags
    import dmac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               csr_we,
    input  logic [CMD_W-1:0]   csr_cmd,
    input  logic               cmp_evt,
    input  logic               fault,
    output chan_flags_t        flags_q,
    output logic               chain
);
    localparam int C_EN  = CMD_SET_EN  - CMD_SET_EN;
    localparam int C_SUP = CMD_SET_SUP - CMD_SET_EN;
    localparam int C_DIR = CMD_DIR     - CMD_SET_EN;
    localparam int C_CLR = CMD_CLR_CMP - CMD_SET_EN;
    localparam int C_RST = CMD_RESET   - CMD_SET_EN;

    chan_flags_t nxt;

    assign chain = cmp_evt & flags_q.sup;

    always_comb begin
        nxt = flags_q;
        if (csr_we) begin
            if (csr_cmd[C_RST]) begin
                nxt.en  = 1'b0;
                nxt.sup = 1'b0;
                nxt.cmp = 1'b0;
                nxt.bex = 1'b0;
            end
            if (csr_cmd[C_CLR] && flags_q.en) nxt.cmp = 1'b0;
            if (csr_cmd[C_EN])  nxt.en  = 1'b1;
            if (csr_cmd[C_SUP]) nxt.sup = 1'b1;
            nxt.d2m = csr_cmd[C_DIR];
        end
        if (cmp_evt) begin
            nxt.cmp = 1'b1;
            if (flags_q.sup) nxt.sup = 1'b0;
            else             nxt.en  = 1'b0;
        end
        if (fault) begin
            nxt.bex = 1'b1;
            nxt.en  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= nxt;
    end
endmodule

// File: rtl/dmac_mover.sv
module dmac_mover #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              d2m,
    input  logic              flush,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              dev_in_valid,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              beat_done,
    output logic              fault
);
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;

    assign dev_in_ready  = run & d2m & ~hold_valid;
    assign dev_out_valid = ~d2m & hold_valid;
    assign dev_out_data  = hold_data;
    assign mem_req       = run & (d2m ? hold_valid : ~hold_valid);
    assign mem_we        = d2m;
    assign mem_addr      = ptr;
    assign mem_wdata     = hold_data;
    assign beat_done     = mem_req & mem_ack & ~mem_err;
    assign fault         = mem_req & mem_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else if (flush) begin
            hold_valid <= 1'b0;
        end else begin
            if (dev_in_ready && dev_in_valid) begin
                hold_valid <= 1'b1;
                hold_data  <= dev_in_data;
            end
            if (beat_done && !d2m) begin
                hold_valid <= 1'b1;
                hold_data  <= mem_rdata;
            end
            if (beat_done && d2m) hold_valid <= 1'b0;
            if (dev_out_valid && dev_out_ready) hold_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
    import dmac_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int ALIGN_LSB = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dev_in_valid,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              irq
);
    localparam int STEP_B = DATA_W / 8;

    reg_idx_e          idx;
    chan_flags_t       flags_q;
    logic              csr_we, flush, run, chain, beat_done, fault, last_beat, cmp_evt;
    logic [ADDR_W-1:0] next_q, limit_q, start_q, stop_q;
    logic [ADDR_W-1:0] sv_next_q, sv_limit_q, sv_start_q, sv_stop_q;

    assign idx     = reg_idx_e'(reg_addr);
    assign csr_we  = reg_we && (idx == RI_CSR);
    assign flush   = (reg_we && idx == RI_INIT_NEXT) || (csr_we && reg_wdata[CMD_FLUSH]);
    assign run     = flags_q.en && !flags_q.bex && (next_q != limit_q);
    assign cmp_evt = beat_done && last_beat;
    assign irq     = flags_q.cmp | flags_q.bex;

    dmac_ptrs #(.ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB), .STEP_B(STEP_B)) u_ptrs (
        .clk(clk), .rst(rst),
        .sw_we(reg_we), .sw_idx(idx), .sw_data(reg_wdata[ADDR_W-1:0]),
        .beat_done(beat_done), .chain(chain), .fault(fault),
        .next_q(next_q), .limit_q(limit_q), .start_q(start_q), .stop_q(stop_q),
        .sv_next_q(sv_next_q), .sv_limit_q(sv_limit_q),
        .sv_start_q(sv_start_q), .sv_stop_q(sv_stop_q),
        .last_beat(last_beat)
    );

    dmac_flags u_flags (
        .clk(clk), .rst(rst),
        .csr_we(csr_we), .csr_cmd(reg_wdata[CMD_RESET:CMD_SET_EN]),
        .cmp_evt(cmp_evt), .fault(fault),
        .flags_q(flags_q), .chain(chain)
    );

    dmac_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mover (
        .clk(clk), .rst(rst),
        .run(run), .d2m(flags_q.d2m), .flush(flush), .ptr(next_q),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .beat_done(beat_done), .fault(fault)
    );

    always_comb begin
        case (idx)
            RI_CSR:       reg_rdata = csr_view(flags_q);
            RI_SV_NEXT:   reg_rdata = REG_W'(sv_next_q);
            RI_SV_LIMIT:  reg_rdata = REG_W'(sv_limit_q);
            RI_SV_START:  reg_rdata = REG_W'(sv_start_q);
            RI_SV_STOP:   reg_rdata = REG_W'(sv_stop_q);
            RI_NEXT,
            RI_INIT_NEXT: reg_rdata = REG_W'(next_q);
            RI_LIMIT:     reg_rdata = REG_W'(limit_q);
            RI_START:     reg_rdata = REG_W'(start_q);
            RI_STOP:      reg_rdata = REG_W'(stop_q);
            default:      reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmac_chan_checker.sv
module dmac_chan_checker
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        reg_addr,
    input logic              reg_we,
    input logic [31:0]       reg_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic              mem_err,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [ADDR_W-1:0] next_q,
    input logic [ADDR_W-1:0] limit_q,
    input logic [ADDR_W-1:0] start_q,
    input logic [ADDR_W-1:0] stop_q,
    input logic [ADDR_W-1:0] sv_next_q,
    input chan_flags_t       flags_q
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

    logic ok_beat, at_last, csr_wr;
    assign ok_beat = mem_req && mem_ack && !mem_err;
    assign at_last = (next_q + STEP) == limit_q;
    assign csr_wr  = reg_we && (reg_addr == 4'd0);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !mem_err && !reg_we) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_no_overrun_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (next_q != limit_q));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (ok_beat && !at_last && !reg_we) |=> (next_q == $past(next_q) + STEP));

    assert_chain_R6: assert property (@(posedge clk) disable iff (rst)
        (ok_beat && at_last && flags_q.sup && !reg_we) |=>
        (next_q == $past(start_q) && limit_q == $past(stop_q) &&
         flags_q.cmp && flags_q.en && !flags_q.sup));

    assert_fault_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_err && !reg_we) |=>
        (!flags_q.en && flags_q.bex && next_q == $past(next_q) && sv_next_q == $past(next_q)));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        flags_q.bex |-> !mem_req);

    assert_clr_cond_R7: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && reg_wdata[CMD_CLR_CMP] && !reg_wdata[CMD_RESET] && !flags_q.en && flags_q.cmp)
        |=> flags_q.cmp);

    assert_rst_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && reg_wdata[CMD_RESET] && !reg_wdata[CMD_SET_EN] && !reg_wdata[CMD_SET_SUP] && !mem_req)
        |=> (!flags_q.en && !flags_q.sup && !flags_q.cmp && !flags_q.bex));
endmodule

bind dma_chain_channel dmac_chan_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .next_q(next_q), .limit_q(limit_q), .start_q(start_q), .stop_q(stop_q),
    .sv_next_q(sv_next_q), .flags_q(flags_q)
);

// File: tb/dma_chain_channel_bench.sv
`timescale 1ns/1ps
module dma_chain_channel_bench;
    localparam int B_EN = 24, B_SUP = 25, B_CMP = 27, B_BEX = 28, B_DIR = 18;
    localparam logic [31:0] C_EN = 32'h1 << 16, C_SUP = 32'h1 << 17, C_D2M = 32'h1 << 18,
                            C_CLR = 32'h1 << 19, C_RST = 32'h1 << 20, C_FL = 32'h1 << 21;

    logic        clk = 1'b0, rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        dev_in_valid = 1'b1, dev_in_ready, dev_out_valid, dev_out_ready = 1'b1;
    logic [31:0] dev_in_data = 32'hD000_0000, dev_out_data;
    logic        mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    logic [63:0] wr_q[$];
    logic [31:0] rd_q[$];
    logic [31:0] src_val = 32'hD000_0000, exp_src = 32'hD000_0000;
    logic [31:0] err_addr = 32'hFFFF_FFF0;
    logic        mem_stall = 1'b0, in_hs_pend = 1'b0;

    always #2 clk = ~clk;

    assign mem_rdata = mem_addr ^ 32'h5A5A_0000;

    dma_chain_channel u_dma_chain_channel (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model, device source and scoreboard monitor
    always @(negedge clk) begin
        if (in_hs_pend) begin
            src_val     = src_val + 1;
            dev_in_data = src_val;
        end
        mem_err = mem_req && (mem_addr == err_addr);
        mem_ack = mem_req && !mem_stall;
        if (mem_req && mem_we && mem_ack && !mem_err) begin
            if (wr_q.size() == 0) check(1'b0, "R4 unexpected write", {mem_addr, mem_wdata}, 64'h0);
            else begin
                logic [63:0] e;
                e = wr_q.pop_front();
                check({mem_addr, mem_wdata} == e, "R4/R6 write", {mem_addr, mem_wdata}, e);
            end
        end
        if (dev_out_valid && dev_out_ready) begin
            if (rd_q.size() == 0) check(1'b0, "R5 unexpected word", 64'(dev_out_data), 64'h0);
            else begin
                logic [31:0] e;
                e = rd_q.pop_front();
                check(dev_out_data == e, "R5 device word", 64'(dev_out_data), 64'(e));
            end
        end
        in_hs_pend = dev_in_valid && dev_in_ready;
    end

    task automatic push_wr(input logic [31:0] base, input int n);
        for (int i = 0; i < n; i++) begin
            wr_q.push_back({base + 32'(4 * i), exp_src});
            exp_src = exp_src + 1;
        end
    endtask

    task automatic push_rd(input logic [31:0] base, input int n);
        for (int i = 0; i < n; i++) rd_q.push_back((base + 32'(4 * i)) ^ 32'h5A5A_0000);
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_bit(input int b, input logic v, input string tag);
        logic [31:0] d;
        for (int i = 0; i < 2000; i++) begin
            reg_rd(4'd0, d);
            if (d[b] == v) return;
        end
        check(1'b0, tag, 64'(d), 64'(v));
    endtask

    task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
        logic [31:0] d;
        reg_rd(a, d);
        check(d == e, tag, 64'(d), 64'(e));
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [31:0] d, a0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_reg(4'd0, 32'h0, "R1 csr");
        expect_reg(4'd5, 32'h0, "R1 next");
        expect_reg(4'd6, 32'h0, "R1 limit");
        check(irq == 1'b0 && mem_req == 1'b0, "R1 irq/req", {irq, mem_req}, 0);

        // R2 alignment
        reg_wr(4'd5, 32'h0000_1004);
        expect_reg(4'd5, 32'h0000_1000, "R2 next aligned");
        reg_wr(4'd8, 32'h0000_203F);
        expect_reg(4'd8, 32'h0000_2030, "R2 stop aligned");

        // R4 single device-to-memory buffer
        reg_wr(4'd5, 32'h100); reg_wr(4'd6, 32'h110);
        push_wr(32'h100, 4);
        reg_wr(4'd0, C_EN | C_D2M);
        wait_bit(B_EN, 1'b0, "R4 enable drop");
        expect_reg(4'd0, (32'h1 << B_CMP) | (32'h1 << B_DIR), "R3 R4 csr after single buffer");
        expect_reg(4'd5, 32'h110, "R4 next at limit");
        check(wr_q.size() == 0, "R4 all words written", 64'(wr_q.size()), 0);
        check(irq == 1'b1, "R10 irq on complete", 64'(irq), 1);

        // R7 clear-complete ignored while disabled
        reg_wr(4'd0, C_CLR | C_D2M);
        expect_reg(4'd0, (32'h1 << B_CMP) | (32'h1 << B_DIR), "R7 complete kept");

        // R8 reset command
        reg_wr(4'd0, C_RST | C_D2M);
        expect_reg(4'd0, 32'h1 << B_DIR, "R8 flags cleared");
        check(irq == 1'b0, "R10 irq low", 64'(irq), 0);

        // R6 chained device-to-memory transfer
        reg_wr(4'd5, 32'h200); reg_wr(4'd6, 32'h210);
        reg_wr(4'd7, 32'h300); reg_wr(4'd8, 32'h320);
        push_wr(32'h200, 4); push_wr(32'h300, 8);
        reg_wr(4'd0, C_EN | C_SUP | C_D2M);
        expect_reg(4'd0, (32'h1 << B_EN) | (32'h1 << B_SUP) | (32'h1 << B_DIR), "R3 csr running armed");
        wait_bit(B_CMP, 1'b1, "R6 first complete");
        expect_reg(4'd6, 32'h320, "R6 limit from stop");
        reg_rd(4'd0, d);
        check(d[B_EN] && !d[B_SUP], "R6 enable kept, chain disarmed", 64'(d), 64'(32'h1 << B_EN));
        reg_wr(4'd0, C_CLR | C_D2M);
        reg_rd(4'd0, d);
        check(d[B_CMP] == 1'b0, "R7 clear while enabled", 64'(d[B_CMP]), 0);
        wait_bit(B_EN, 1'b0, "R6 second buffer end");
        expect_reg(4'd0, (32'h1 << B_CMP) | (32'h1 << B_DIR), "R6 final csr");
        expect_reg(4'd5, 32'h320, "R6 next at stop");
        check(wr_q.size() == 0, "R6 all chained words", 64'(wr_q.size()), 0);

        // R5 / R12 memory-to-device with stall
        reg_wr(4'd0, C_RST);
        reg_wr(4'd5, 32'h400); reg_wr(4'd6, 32'h420);
        push_rd(32'h400, 8);
        mem_stall = 1'b1;
        reg_wr(4'd0, C_EN);
        @(negedge clk); #1;
        a0 = mem_addr;
        repeat (4) @(negedge clk);
        #1;
        check(mem_req && mem_addr == a0 && !mem_we, "R12 request held", {mem_req, mem_addr}, {1'b1, a0});
        mem_stall = 1'b0;
        wait_bit(B_EN, 1'b0, "R5 read buffer end");
        repeat (3) @(negedge clk);
        check(rd_q.size() == 0, "R5 all words delivered", 64'(rd_q.size()), 0);
        expect_reg(4'd0, 32'h1 << B_CMP, "R5 csr complete");

        // R11 flush via init-next and via CSR
        reg_wr(4'd0, C_RST);
        reg_wr(4'd5, 32'h500); reg_wr(4'd6, 32'h510);
        dev_out_ready = 1'b0;
        reg_wr(4'd0, C_EN);
        repeat (3) @(negedge clk);
        check(dev_out_valid == 1'b1, "R11 holding filled", 64'(dev_out_valid), 1);
        reg_wr(4'd0, C_RST);
        reg_wr(4'd9, 32'h0000_0508);
        #1;
        check(dev_out_valid == 1'b0, "R11 init-next flush", 64'(dev_out_valid), 0);
        expect_reg(4'd5, 32'h500, "R11 R2 init-next loads next");
        reg_wr(4'd0, C_EN);
        repeat (3) @(negedge clk);
        check(dev_out_valid == 1'b1, "R11 holding refilled", 64'(dev_out_valid), 1);
        reg_wr(4'd0, C_RST | C_FL);
        #1;
        check(dev_out_valid == 1'b0, "R11 csr flush", 64'(dev_out_valid), 0);
        dev_out_ready = 1'b1;

        // R9 bus error coinciding with the last-word acknowledge of an armed buffer
        reg_wr(4'd5, 32'h600); reg_wr(4'd6, 32'h620);
        reg_wr(4'd7, 32'h700); reg_wr(4'd8, 32'h710);
        err_addr = 32'h61C;
        push_wr(32'h600, 7);
        exp_src = exp_src + 1;
        reg_wr(4'd0, C_EN | C_SUP | C_D2M);
        wait_bit(B_BEX, 1'b1, "R9 fault seen");
        expect_reg(4'd0, (32'h1 << B_BEX) | (32'h1 << B_SUP) | (32'h1 << B_DIR), "R9 csr after fault");
        expect_reg(4'd5, 32'h61C, "R9 next not advanced");
        expect_reg(4'd1, 32'h61C, "R9 saved next");
        expect_reg(4'd2, 32'h620, "R9 saved limit");
        expect_reg(4'd3, 32'h700, "R9 saved start");
        expect_reg(4'd4, 32'h710, "R9 saved stop");
        check(irq == 1'b1, "R10 irq on fault", 64'(irq), 1);
        repeat (5) @(negedge clk);
        #1;
        check(mem_req == 1'b0 && dev_in_ready == 1'b0, "R9 channel frozen", {mem_req, dev_in_ready}, 0);
        check(wr_q.size() == 0, "R9 writes before fault", 64'(wr_q.size()), 0);
        reg_wr(4'd0, C_RST | C_FL);
        expect_reg(4'd0, 32'h0, "R8 fault cleared");
        check(irq == 1'b0, "R10 irq cleared", 64'(irq), 0);

        summary();
    end
endmodule